// File: doc/BRIEF.md
# Periodic Peripheral Autopoll Scheduler

This block issues periodic poll requests to a peripheral bus while autopolling is switched on. A millisecond tick is derived from the system clock by a prescaler, and a programmable number of milliseconds sets the poll period. Each poll request is a single-cycle strobe. It carries a 16-bit device mask that selects which bus addresses may answer.

A command decoder elsewhere in the system drives three update strobes: one for the enable, one for the period and one for the mask. When the bus answers with a non-empty result, the block frames the bytes as an unsolicited packet and sends it one byte at a time to the host link over a valid/ready stream. Every packet starts with a kind byte and a tag byte. The tag marks the data as polled rather than as the reply to a host request.

The timer is re-armed after every poll response. It also restarts at once when the period is changed while polling is active. While a poll is outstanding or a packet is still being sent, no new poll is issued.

Top module: `autopoll_sched`

## Requirements
- R1: After reset, autopolling is off and no poll strobe appears however long the block idles. `pkt_valid` is low, the period is 20 ms, and `poll_mask` reads 0xFFFF (every address selected).
- R2: A write that turns autopolling on arms the timer for one full period. The first `poll_req` is high exactly `rate*CLK_PER_MS + 2` cycles after the cycle in which the enable write was driven.
- R3: A write that turns autopolling off cancels the armed timer, and no `poll_req` appears afterwards.
- R4: Writing the enable with the value it already holds has no effect. A repeated "on" does not restart the timer, and a repeated "off" does not start it.
- R5: A non-zero period write while polling is on restarts the timer with the new period, counted from that write. While polling is off, the write only stores the period for the next enable.
- R6: A period write of 0 is ignored. The stored period and the running timer are both left unchanged.
- R7: `poll_req` is high for exactly one cycle per poll. During that cycle `poll_mask` holds the most recently written mask.
- R8: A response with a non-zero length `n` produces one packet of `n+2` bytes: 0x00, then 0x40, then response bytes 0 to n-1 (byte i at `rsp_data[8*i +: 8]`). `pkt_last` is set on the final byte only. While `pkt_valid` is high and `pkt_ready` is low, the byte and `pkt_last` hold steady.
- R9: A response of length 0 produces no packet.
- R10: Every accepted poll response re-arms the timer if polling is on. The next `poll_req` appears `rate*CLK_PER_MS + 2` cycles after the cycle in which the response was driven. No poll is issued while a packet byte is pending.
- R11: A `rsp_valid` pulse that arrives while no poll is outstanding is ignored and produces no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_wr | input | 1 | Enable update strobe |
| cfg_en_val | input | 1 | New enable value |
| cfg_rate_wr | input | 1 | Period update strobe |
| cfg_rate_val | input | RATE_W | New period in milliseconds (0 ignored) |
| cfg_mask_wr | input | 1 | Mask update strobe |
| cfg_mask_val | input | MASK_W | New device mask |
| poll_req | output | 1 | Single-cycle poll strobe |
| poll_mask | output | MASK_W | Device mask carried with the poll |
| rsp_valid | input | 1 | Poll response valid (one cycle) |
| rsp_len | input | LEN_W | Response byte count |
| rsp_data | input | MAX_LEN*DATA_W | Response bytes, byte 0 in the low bits |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_ready | input | 1 | Host link accepts the byte |
| pkt_data | output | DATA_W | Packet byte |
| pkt_last | output | 1 | Final byte of the packet |

## Verification
A wrong timer state shows at the ports as a `poll_req` that comes early, comes late or never comes. The bench therefore measures every poll against the cycle-exact distance from the write or response that armed the timer, so a single lost prescaler step is seen within one period. A corrupted enable or period register shows up at the next expected poll, either as a missing poll or as a changed interval. A framer index error shows within the same packet as a wrong header, a misplaced byte or a misplaced last flag.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
  localparam logic [7:0] KIND_PERIPH     = 8'h00;
  localparam logic [7:0] TAG_UNSOLICITED = 8'h40;

  typedef enum logic {
    CTL_IDLE,
    CTL_WAIT
  } ctl_state_e;
endpackage

// File: rtl/ap_ms_timer.sv
module ap_ms_timer #(
  parameter int CLK_PER_MS = 1000,
  parameter int RATE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              cancel,
  input  logic [RATE_W-1:0] period,
  output logic              expired
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_MS - 1);

  logic              armed;
  logic [RATE_W-1:0] ms_left;
  logic [PRE_W-1:0]  pre;

  // cancel wins over arm; the controller never raises both together
  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      armed   <= 1'b0;
      ms_left <= '0;
      pre     <= '0;
    end else if (arm) begin
      armed   <= 1'b1;
      ms_left <= period;
      pre     <= '0;
    end else if (armed && ms_left != '0) begin
      if (pre == PRE_MAX) begin
        pre     <= '0;
        ms_left <= ms_left - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired = armed && (ms_left == '0);
endmodule

// File: rtl/ap_framer.sv
module ap_framer
  import autopoll_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [LEN_W-1:0]          load_len,
  input  logic [MAX_LEN*DATA_W-1:0] load_data,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_last,
  output logic                      busy
);
  localparam int IDX_W  = $clog2(MAX_LEN + 2);
  localparam int MEM_AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [DATA_W-1:0] mem [MAX_LEN];
  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  eff_len;
  logic [DATA_W-1:0] sel_byte;
  logic              sel_last;
  logic [MEM_AW-1:0] mem_addr;

  assign eff_len = (load_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : load_len;

  // response buffer: one write port per slot, filled in a single cycle
  for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load && !active) mem[g] <= load_data[g*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    mem_addr = MEM_AW'(idx - IDX_W'(2));
    if (idx == '0)              sel_byte = DATA_W'(KIND_PERIPH);
    else if (idx == IDX_W'(1))  sel_byte = DATA_W'(TAG_UNSOLICITED);
    else                        sel_byte = mem[mem_addr];
    sel_last = (idx == IDX_W'(len_q) + IDX_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      idx       <= '0;
      len_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (load && !active && eff_len != '0) begin
        active <= 1'b1;
        idx    <= '0;
        len_q  <= eff_len;
      end else if (active && (!out_valid || out_ready)) begin
        idx <= idx + 1'b1;
        if (sel_last) active <= 1'b0;
      end

      if (active && (!out_valid || out_ready)) begin
        out_valid <= 1'b1;
        out_data  <= sel_byte;
        out_last  <= sel_last;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign busy = active || out_valid;
endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
  import autopoll_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int RATE_W     = 8,
  parameter int MASK_W     = 16,
  parameter int DATA_W     = 8,
  parameter int MAX_LEN    = 8,
  parameter int LEN_W      = $clog2(MAX_LEN + 1),
  parameter int DEF_RATE   = 20,
  parameter logic [MASK_W-1:0] DEF_MASK = '1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_en_wr,
  input  logic                      cfg_en_val,
  input  logic                      cfg_rate_wr,
  input  logic [RATE_W-1:0]         cfg_rate_val,
  input  logic                      cfg_mask_wr,
  input  logic [MASK_W-1:0]         cfg_mask_val,
  output logic                      poll_req,
  output logic [MASK_W-1:0]         poll_mask,
  input  logic                      rsp_valid,
  input  logic [LEN_W-1:0]          rsp_len,
  input  logic [MAX_LEN*DATA_W-1:0] rsp_data,
  output logic                      pkt_valid,
  input  logic                      pkt_ready,
  output logic [DATA_W-1:0]         pkt_data,
  output logic                      pkt_last
);
  ctl_state_e        state;
  logic              en_q;
  logic [RATE_W-1:0] rate_q;
  logic [MASK_W-1:0] mask_q;

  logic              en_set, en_clr, en_next;
  logic              rate_ok;
  logic [RATE_W-1:0] rate_next;
  logic              rsp_accept;
  logic              issue;
  logic              tmr_arm, tmr_cancel, tmr_expired;
  logic              frm_busy;

  always_comb begin
    en_set     = cfg_en_wr && cfg_en_val && !en_q;
    en_clr     = cfg_en_wr && !cfg_en_val && en_q;
    en_next    = en_set ? 1'b1 : (en_clr ? 1'b0 : en_q);
    rate_ok    = cfg_rate_wr && (cfg_rate_val != '0);
    rate_next  = rate_ok ? cfg_rate_val : rate_q;
    rsp_accept = (state == CTL_WAIT) && rsp_valid;
    // a period change in the expiry cycle restarts instead of polling
    issue      = tmr_expired && en_q && !en_clr && !rate_ok &&
                 (state == CTL_IDLE) && !frm_busy;
    tmr_arm    = en_set || (rate_ok && en_next) || (rsp_accept && en_next);
    tmr_cancel = en_clr || issue;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CTL_IDLE;
      en_q     <= 1'b0;
      rate_q   <= RATE_W'(DEF_RATE);
      mask_q   <= DEF_MASK;
      poll_req <= 1'b0;
    end else begin
      en_q     <= en_next;
      rate_q   <= rate_next;
      poll_req <= issue;
      if (cfg_mask_wr) mask_q <= cfg_mask_val;
      if (issue)           state <= CTL_WAIT;
      else if (rsp_accept) state <= CTL_IDLE;
    end
  end

  assign poll_mask = mask_q;

  ap_ms_timer #(
    .CLK_PER_MS(CLK_PER_MS),
    .RATE_W    (RATE_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm    (tmr_arm),
    .cancel (tmr_cancel),
    .period (rate_next),
    .expired(tmr_expired)
  );

  ap_framer #(
    .DATA_W (DATA_W),
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .load     (rsp_accept),
    .load_len (rsp_len),
    .load_data(rsp_data),
    .out_ready(pkt_ready),
    .out_valid(pkt_valid),
    .out_data (pkt_data),
    .out_last (pkt_last),
    .busy     (frm_busy)
  );
endmodule

// File: rtl/ap_checker.sv
module ap_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              poll_req,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic [DATA_W-1:0] pkt_data,
  input logic              pkt_last,
  input logic              en_q
);
  assert_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    poll_req |=> !poll_req);

  assert_no_poll_off_R3: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !poll_req);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

  assert_header_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_valid) |-> (pkt_data == '0 && !pkt_last));

  assert_no_poll_busy_R10: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> !poll_req);
endmodule

bind autopoll_sched ap_checker #(.DATA_W(DATA_W)) u_ap_checker (
  .clk      (clk),
  .rst      (rst),
  .poll_req (poll_req),
  .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready),
  .pkt_data (pkt_data),
  .pkt_last (pkt_last),
  .en_q     (en_q)
);

// File: tb/autopoll_sched_bench.sv
module autopoll_sched_bench;
  localparam int P    = 8;
  localparam int MAXL = 8;
  localparam int LW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en_wr = 0, cfg_en_val = 0, cfg_rate_wr = 0, cfg_mask_wr = 0;
  logic [7:0]  cfg_rate_val = '0;
  logic [15:0] cfg_mask_val = '0;
  logic        poll_req;
  logic [15:0] poll_mask;
  logic        rsp_valid = 0;
  logic [LW-1:0] rsp_len = '0;
  logic [MAXL*8-1:0] rsp_data = '0;
  logic        pkt_valid, pkt_ready = 0, pkt_last;
  logic [7:0]  pkt_data;

  autopoll_sched #(.CLK_PER_MS(P)) u_autopoll_sched (
    .clk(clk), .rst(rst),
    .cfg_en_wr(cfg_en_wr), .cfg_en_val(cfg_en_val),
    .cfg_rate_wr(cfg_rate_wr), .cfg_rate_val(cfg_rate_val),
    .cfg_mask_wr(cfg_mask_wr), .cfg_mask_val(cfg_mask_val),
    .poll_req(poll_req), .poll_mask(poll_mask),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_last(pkt_last)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  int total = 0, bad = 0;
  int poll_cnt = 0, last_poll_cyc = 0, strobe_bad = 0, frame_starts = 0;
  logic [15:0] last_poll_mask = '0;
  logic prev_poll = 0, prev_valid = 0;
  logic [7:0] rbuf [MAXL];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (poll_req) begin
        poll_cnt++;
        last_poll_cyc  = cyc;
        last_poll_mask = poll_mask;
        if (prev_poll) strobe_bad++;
      end
      if (pkt_valid && !prev_valid) frame_starts++;
      prev_poll  = poll_req;
      prev_valid = pkt_valid;
    end
  end

  function automatic int exp_delay(input int rate);
    return rate * P + 2;
  endfunction

  function automatic logic [7:0] exp_byte(input int idx);
    if (idx == 0) return 8'h00;
    if (idx == 1) return 8'h40;
    return rbuf[idx-2];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_en(input logic v, output int at);
    @(negedge clk); cfg_en_wr = 1; cfg_en_val = v; at = cyc;
    @(negedge clk); cfg_en_wr = 0;
  endtask

  task automatic do_rate(input logic [7:0] v, output int at);
    @(negedge clk); cfg_rate_wr = 1; cfg_rate_val = v; at = cyc;
    @(negedge clk); cfg_rate_wr = 0;
  endtask

  task automatic do_mask(input logic [15:0] v);
    @(negedge clk); cfg_mask_wr = 1; cfg_mask_val = v;
    @(negedge clk); cfg_mask_wr = 0;
  endtask

  task automatic do_rsp(input int len, output int at);
    @(negedge clk);
    for (int i = 0; i < MAXL; i++) rsp_data[i*8 +: 8] = rbuf[i];
    rsp_len = LW'(len); rsp_valid = 1; at = cyc;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic wait_poll(input int n0);
    while (poll_cnt == n0) @(posedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(posedge clk);
  endtask

  task automatic fill_rand(input int len);
    for (int i = 0; i < MAXL; i++) rbuf[i] = (i < len) ? 8'($urandom) : 8'hEE;
  endtask

  task automatic collect(input int len);
    int got = 0, guard = 0, mism = 0, unstable = 0, stall = 0;
    logic prev_stall = 0;
    logic [7:0] prev_d = '0;
    logic prev_l = 0;
    while (got < len + 2 && guard < 400) begin
      @(negedge clk); guard++;
      if (prev_stall && (!pkt_valid || pkt_data != prev_d || pkt_last != prev_l)) unstable++;
      pkt_ready = (stall >= 2) ? 1'b1 : (($urandom % 4) != 0);
      if (pkt_valid && pkt_ready) begin
        if (pkt_data != exp_byte(got) || pkt_last != (got == len + 1)) mism++;
        got++; stall = 0;
      end else if (pkt_valid) stall++;
      prev_stall = pkt_valid && !pkt_ready;
      prev_d = pkt_data; prev_l = pkt_last;
    end
    @(negedge clk); pkt_ready = 0;
    chk(got == len + 2, "R8 packet length", got, len + 2);
    chk(mism == 0, "R8 packet bytes/last", mism, 0);
    chk(unstable == 0, "R8 hold under backpressure", unstable, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t, tr, tr2, tw, n, fs, len, rate;
    void'($urandom(32'd4711));
    for (int i = 0; i < MAXL; i++) rbuf[i] = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(poll_req == 0, "R1 poll_req at reset", poll_req, 0);
    chk(pkt_valid == 0, "R1 pkt_valid at reset", pkt_valid, 0);
    chk(poll_mask == 16'hFFFF, "R1 default mask", poll_mask, 16'hFFFF);
    repeat (400) @(posedge clk);
    chk(poll_cnt == 0, "R1 disabled after reset", poll_cnt, 0);

    // R2: enable with default 20 ms period
    n = poll_cnt; do_en(1, t); wait_poll(n);
    chk(last_poll_cyc - t == exp_delay(20), "R2 first poll delay", last_poll_cyc - t, exp_delay(20));
    chk(last_poll_mask == 16'hFFFF, "R7 default mask on poll", last_poll_mask, 16'hFFFF);

    // R8 then R10: frame and re-arm
    fill_rand(3); repeat (3) @(posedge clk);
    n = poll_cnt; do_rsp(3, tr); collect(3);
    wait_poll(n);
    chk(last_poll_cyc - tr == exp_delay(20), "R10 re-arm after response", last_poll_cyc - tr, exp_delay(20));

    // R9: empty result
    fs = frame_starts; n = poll_cnt; do_rsp(0, tr);
    repeat (60) @(posedge clk);
    chk(frame_starts == fs, "R9 no packet for empty result", frame_starts - fs, 0);

    // R4: repeated enable does not restart
    wait_until(tr + 40); do_en(1, t); wait_poll(n);
    chk(last_poll_cyc - tr == exp_delay(20), "R4 repeated on ignored", last_poll_cyc - tr, exp_delay(20));
    n = poll_cnt; do_rsp(0, tr2);

    // R5: period change while active restarts timer
    wait_until(tr2 + 30); do_rate(5, tw); wait_poll(n);
    chk(last_poll_cyc - tw == exp_delay(5), "R5 restart on new period", last_poll_cyc - tw, exp_delay(5));
    n = poll_cnt; do_rsp(0, tr);

    // R6: zero period ignored
    wait_until(tr + 10); do_rate(0, tw); wait_poll(n);
    chk(last_poll_cyc - tr == exp_delay(5), "R6 zero period ignored", last_poll_cyc - tr, exp_delay(5));
    n = poll_cnt; do_rsp(0, tr); wait_poll(n);
    chk(last_poll_cyc - tr == exp_delay(5), "R6 period kept after zero write", last_poll_cyc - tr, exp_delay(5));
    n = poll_cnt; do_rsp(0, tr);

    // R3: disable before expiry cancels
    wait_until(tr + 10); do_en(0, t);
    do_rate(3, tw);
    do_en(0, t);
    repeat (200) @(posedge clk);
    chk(poll_cnt == n, "R3 no poll after disable", poll_cnt - n, 0);
    chk(poll_cnt == n, "R4 repeated off ignored", poll_cnt - n, 0);

    // R11: stray response while idle
    fs = frame_starts; fill_rand(4); do_rsp(4, tr);
    repeat (50) @(posedge clk);
    chk(frame_starts == fs, "R11 stray response ignored", frame_starts - fs, 0);

    // R5: stored period used on next enable; R7 mask
    do_mask(16'h0A5C);
    do_en(1, t); wait_poll(n);
    chk(last_poll_cyc - t == exp_delay(3), "R5 stored period on enable", last_poll_cyc - t, exp_delay(3));
    chk(last_poll_mask == 16'h0A5C, "R7 mask on poll", last_poll_mask, 16'h0A5C);
    n = poll_cnt; do_rsp(0, tr); do_en(0, t);

    // random mix
    for (int it = 0; it < 14; it++) begin
      logic [15:0] m;
      m = 16'($urandom); rate = 4 + ($urandom % 5); len = $urandom % (MAXL + 1);
      do_mask(m); do_rate(8'(rate), tw);
      n = poll_cnt; do_en(1, t); wait_poll(n);
      chk(last_poll_cyc - t == exp_delay(rate), "R2 random poll delay", last_poll_cyc - t, exp_delay(rate));
      chk(last_poll_mask == m, "R7 random mask", last_poll_mask, m);
      fill_rand(len); repeat ($urandom % 5) @(posedge clk);
      fs = frame_starts; n = poll_cnt; do_rsp(len, tr);
      if (len > 0) collect(len);
      else begin
        repeat (10) @(posedge clk);
        chk(frame_starts == fs, "R9 random empty result", frame_starts - fs, 0);
      end
      wait_poll(n);
      chk(last_poll_cyc - tr == exp_delay(rate), "R10 random re-arm", last_poll_cyc - tr, exp_delay(rate));
      n = poll_cnt; do_rsp(0, tr); do_en(0, t);
    end

    chk(strobe_bad == 0, "R7 single-cycle strobe", strobe_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule